// File: doc/BRIEF.md
# Deep-Sleep Halt Sequencer

This block sequences the two lowest-power sleep states of a small microcontroller. When the core reports that it has executed a halt instruction, the sequencer samples the oscillator-interrupt-enable bit. If that bit is set, the block enters a clock-keeping halt, where only the oscillator and its timebase keep running. If the bit is clear, it enters a full halt, where every clock stops. The block drives the oscillator, CPU and peripheral clock enables and the interrupt mask bits. It also signals the core when to service an interrupt and when to fetch the reset vector.

The wake path decides the stabilisation delay. A timebase interrupt that ends the clock-keeping halt restores the CPU clock at once. Every other way out goes through a delay state that counts a selectable 256 or 4096 CPU cycles before the clocks return: a chip reset from any state, or an external interrupt that ends the full halt. A reset request takes priority over any interrupt in the same cycle. A reset that arrives during the delay restarts the count.

Top module: `hlt_power_ctrl`

## Requirements
- R1: While the sequencer is running, a halt request moves it to the clock-keeping halt state (status code 1) when the oscillator-interrupt-enable input is 1. It moves to the full halt state (code 2) when that input is 0. The status codes are 0 run, 1 clock-keeping halt, 2 full halt and 3 delay.
- R2: Once entered, the delay state lasts exactly 256 cycles when the delay-select input is 0 and exactly 4096 cycles when it is 1.
- R3: In the clock-keeping halt state the oscillator enable is 1 and the CPU and peripheral enables are both 0.
- R4: In the clock-keeping halt state the external interrupt lines have no effect, and the state is held.
- R5: A timebase interrupt in the clock-keeping halt state returns the block to run on the next edge with no delay. The CPU and peripheral enables go to 1, and the interrupt-service output pulses high for one cycle.
- R6: A reset request in any state enters the delay state. During the delay the oscillator enable is 1 and the CPU and peripheral enables are 0. When the delay ends, all enables go to 1 and the reset-vector output pulses for one cycle.
- R7: The registered mask output is 2'b10 while in the clock-keeping halt state and follows the core mask input one cycle later in the other states. A timebase interrupt already pending when the halt is taken ends the halt on the very next edge.
- R8: A halt request with the oscillator-interrupt-enable input at 1 never raises the watchdog-reset output, even with the watchdog running. With that input at 0 and the watchdog running, the halt is refused: the watchdog-reset output pulses for one cycle and the block stays in run.
- R9: In the full halt state all three clock enables are 0 and the timebase interrupt is ignored. An external interrupt enters the delay state, and after the delay the interrupt-service output pulses for one cycle.
- R10: A reset request arriving in the same cycle as a timebase interrupt wins: the block goes to delay and no interrupt-service pulse is produced. A reset request during the delay reloads the count, so the delay runs its full length from that edge.
- R11: After the block reset, the status is run, all three clock enables are 1, the mask output is 2'b00 and the interrupt-service, reset-vector and watchdog-reset outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock, running in all states |
| rst_n | input | 1 | Active-low reset of the sequencer's own registers |
| halt_req | input | 1 | Core reports a halt instruction |
| osc_irq_en | input | 1 | Oscillator-interrupt-enable bit; picks the halt flavour |
| long_dly_sel | input | 1 | Static option: 0 selects 256 cycles, 1 selects 4096 cycles |
| tb_irq | input | 1 | Timebase interrupt from the oscillator counter |
| ext_irq | input | NUM_EXT | External interrupt lines |
| sys_rst_req | input | 1 | Chip reset event (wake source) |
| wdg_on | input | 1 | Watchdog is running |
| core_imask | input | 2 | Interrupt mask bits from the core |
| osc_clk_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask | output | 2 | Interrupt mask bits driven to the core |
| irq_service | output | 1 | One-cycle request to service an interrupt |
| fetch_rst_vec | output | 1 | One-cycle request to fetch the reset vector |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |
| state_o | output | 2 | Current state code |

## Verification
The bench goes after the off-by-one edges of the delay. It counts the cycles spent in delay for both option values and again after a reset restarts the count midway, so a counter loaded one short, or one that resumes instead of reloading, shows a wrong cycle total. It drives a timebase interrupt and a reset in the same cycle, where a design with the priority reversed would raise an interrupt-service pulse and skip the delay. It also drives external interrupts into the clock-keeping halt and timebase interrupts into the full halt; a design that accepted either would wake from the wrong state. A pending timebase interrupt at halt entry and both watchdog cases catch a design that swallows the early wake or raises a watchdog reset from the clock-keeping halt.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_AHALT = 2'd1,
      ST_FHALT = 2'd2,
      ST_DELAY = 2'd3
   } hlt_state_t;

   localparam logic [1:0] MASK_OPEN = 2'b10;

endpackage

// File: rtl/hlt_wake_src.sv
module hlt_wake_src #(
   parameter int NUM_EXT  = 4,
   parameter bit EXT_SYNC = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_irq,
   output logic               ext_any
);

   generate
      if (NUM_EXT < 1) begin : g_bad_width
         $error("hlt_wake_src: NUM_EXT must be at least 1");
      end

      if (EXT_SYNC) begin : g_sync
         logic any_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) any_q <= 1'b0;
            else        any_q <= |ext_irq;
         end
         assign ext_any = any_q;
      end else begin : g_direct
         assign ext_any = |ext_irq;
      end
   endgenerate

endmodule

// File: rtl/hlt_delay_cnt.sv
module hlt_delay_cnt #(
   parameter int SHORT_DLY = 256,
   parameter int LONG_DLY  = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic long_sel,
   input  logic en,
   output logic done
);

   localparam int CNT_W = $clog2(LONG_DLY);
   localparam logic [CNT_W-1:0] SHORT_INIT = CNT_W'(SHORT_DLY - 1);
   localparam logic [CNT_W-1:0] LONG_INIT  = CNT_W'(LONG_DLY - 1);

   generate
      if (SHORT_DLY < 2) begin : g_bad_short
         $error("hlt_delay_cnt: SHORT_DLY must be at least 2");
      end
      if (LONG_DLY <= SHORT_DLY) begin : g_bad_order
         $error("hlt_delay_cnt: LONG_DLY must exceed SHORT_DLY");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= long_sel ? LONG_INIT : SHORT_INIT;
      end else if (en && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = en && (cnt_q == '0) && !load;

   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == ($past(long_sel) ? LONG_INIT : SHORT_INIT))); // R2

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/hlt_power_ctrl.sv
module hlt_power_ctrl
   import hlt_pkg::*;
#(
   parameter int NUM_EXT   = 4,
   parameter bit EXT_SYNC  = 1'b0,
   parameter int SHORT_DLY = 256,
   parameter int LONG_DLY  = 4096
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt_req,
   input  logic               osc_irq_en,
   input  logic               long_dly_sel,
   input  logic               tb_irq,
   input  logic [NUM_EXT-1:0] ext_irq,
   input  logic               sys_rst_req,
   input  logic               wdg_on,
   input  logic [1:0]         core_imask,
   output logic               osc_clk_en,
   output logic               cpu_clk_en,
   output logic               per_clk_en,
   output logic [1:0]         imask,
   output logic               irq_service,
   output logic               fetch_rst_vec,
   output logic               wdg_rst_req,
   output logic [1:0]         state_o
);

   hlt_state_t state_q, state_d;
   logic       ext_any;
   logic       dly_done;
   logic       dly_load;
   logic       why_rst_q, why_rst_d;
   logic       svc_d, fetch_d, wdg_d;

   logic       osc_q, cpu_q, per_q, svc_q, fetch_q, wdg_q;
   logic [1:0] imask_q;

   hlt_wake_src #(
      .NUM_EXT  (NUM_EXT),
      .EXT_SYNC (EXT_SYNC)
   ) u_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_irq (ext_irq),
      .ext_any (ext_any)
   );

   hlt_delay_cnt #(
      .SHORT_DLY (SHORT_DLY),
      .LONG_DLY  (LONG_DLY)
   ) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dly_load),
      .long_sel (long_dly_sel),
      .en       (state_q == ST_DELAY),
      .done     (dly_done)
   );

   // Next-state decision; a reset request outranks every other event.
   always_comb begin
      state_d   = state_q;
      why_rst_d = why_rst_q;
      dly_load  = 1'b0;
      svc_d     = 1'b0;
      fetch_d   = 1'b0;
      wdg_d     = 1'b0;
      if (sys_rst_req) begin
         state_d   = ST_DELAY;
         why_rst_d = 1'b1;
         dly_load  = 1'b1;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (halt_req) begin
                  if (osc_irq_en)  state_d = ST_AHALT;
                  else if (wdg_on) wdg_d   = 1'b1;
                  else             state_d = ST_FHALT;
               end
            end
            ST_AHALT: begin
               if (tb_irq) begin
                  state_d = ST_RUN;
                  svc_d   = 1'b1;
               end
            end
            ST_FHALT: begin
               if (ext_any) begin
                  state_d   = ST_DELAY;
                  why_rst_d = 1'b0;
                  dly_load  = 1'b1;
               end
            end
            ST_DELAY: begin
               if (dly_done) begin
                  state_d = ST_RUN;
                  fetch_d = why_rst_q;
                  svc_d   = !why_rst_q;
               end
            end
            default: state_d = ST_RUN;
         endcase
      end
   end

   // All outputs are registered from the next-state view.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN;
         why_rst_q <= 1'b0;
         osc_q     <= 1'b1;
         cpu_q     <= 1'b1;
         per_q     <= 1'b1;
         imask_q   <= 2'b00;
         svc_q     <= 1'b0;
         fetch_q   <= 1'b0;
         wdg_q     <= 1'b0;
      end else begin
         state_q   <= state_d;
         why_rst_q <= why_rst_d;
         osc_q     <= (state_d != ST_FHALT);
         cpu_q     <= (state_d == ST_RUN);
         per_q     <= (state_d == ST_RUN);
         imask_q   <= (state_d == ST_AHALT) ? MASK_OPEN : core_imask;
         svc_q     <= svc_d;
         fetch_q   <= fetch_d;
         wdg_q     <= wdg_d;
      end
   end

   assign osc_clk_en    = osc_q;
   assign cpu_clk_en    = cpu_q;
   assign per_clk_en    = per_q;
   assign imask         = imask_q;
   assign irq_service   = svc_q;
   assign fetch_rst_vec = fetch_q;
   assign wdg_rst_req   = wdg_q;
   assign state_o       = state_q;

   AST_AHALT_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AHALT) |-> (osc_clk_en && !cpu_clk_en && !per_clk_en)); // R3

   AST_AHALT_IGNORE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AHALT && !tb_irq && !sys_rst_req) |=> (state_q == ST_AHALT)); // R4

   AST_TB_FAST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AHALT && tb_irq && !sys_rst_req) |=> (state_q == ST_RUN && irq_service)); // R5

   AST_DELAY_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DELAY) |-> (osc_clk_en && !cpu_clk_en)); // R6

   AST_WAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_service, fetch_rst_vec})); // R6

   AST_NO_WDG_AHALT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && halt_req && osc_irq_en) |=> !wdg_rst_req); // R8

   AST_FHALT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FHALT) |-> (!osc_clk_en && !cpu_clk_en && !per_clk_en)); // R9

   AST_RST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> (state_q == ST_DELAY && !irq_service)); // R10

endmodule

// File: tb/hlt_power_ctrl_tb.sv
module hlt_power_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt_req = 1'b0;
   logic       osc_irq_en = 1'b0;
   logic       long_dly_sel = 1'b0;
   logic       tb_irq = 1'b0;
   logic [3:0] ext_irq = '0;
   logic       sys_rst_req = 1'b0;
   logic       wdg_on = 1'b0;
   logic [1:0] core_imask = 2'b00;
   logic       osc_clk_en, cpu_clk_en, per_clk_en;
   logic [1:0] imask;
   logic       irq_service, fetch_rst_vec, wdg_rst_req;
   logic [1:0] state_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   hlt_power_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
      .long_dly_sel(long_dly_sel), .tb_irq(tb_irq), .ext_irq(ext_irq),
      .sys_rst_req(sys_rst_req), .wdg_on(wdg_on), .core_imask(core_imask),
      .osc_clk_en(osc_clk_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .imask(imask), .irq_service(irq_service), .fetch_rst_vec(fetch_rst_vec),
      .wdg_rst_req(wdg_rst_req), .state_o(state_o)
   );

   // {oie, wdg, exp_state[1:0], exp_wdg, exp_osc, exp_cpu}
   localparam logic [6:0] VEC [4] = '{
      7'b0_0_10_0_0_0,
      7'b0_1_00_1_1_1,
      7'b1_0_01_0_1_0,
      7'b1_1_01_0_1_0
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   // Counts negedges spent in the delay state; call at the negedge right after entry.
   task automatic run_delay(output int n);
      n = 0;
      while (state_o == 2'd3 && n < 10000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int n;
      // R11 reset state
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      eq("R11 state", state_o, 0);
      eq("R11 clocks", {osc_clk_en, cpu_clk_en, per_clk_en}, 7);
      eq("R11 imask", imask, 0);
      eq("R11 pulses", {irq_service, fetch_rst_vec, wdg_rst_req}, 0);

      // R7 mask follows the core in run
      core_imask = 2'b01;
      tick();
      eq("R7 run mask", imask, 1);

      // Vector table: R1 halt choice, R8 watchdog, R3/R9 clocks
      for (int i = 0; i < 4; i++) begin
         osc_irq_en = VEC[i][6];
         wdg_on     = VEC[i][5];
         halt_req   = 1'b1;
         tick();
         halt_req   = 1'b0;
         eq("R1 halt state", state_o, int'(VEC[i][4:3]));
         eq("R8 wdg request", wdg_rst_req, VEC[i][2]);
         eq("R3 R9 osc enable", osc_clk_en, VEC[i][1]);
         eq("R3 R9 cpu enable", cpu_clk_en, VEC[i][0]);
         if (state_o == 2'd1) begin
            eq("R7 halt mask", imask, 2);
            tb_irq = 1'b1;
            tick();
            tb_irq = 1'b0;
            eq("R5 fast wake state", state_o, 0);
            eq("R5 service pulse", irq_service, 1);
            eq("R5 cpu back", {cpu_clk_en, per_clk_en}, 3);
            tick();
            eq("R5 pulse one cycle", irq_service, 0);
         end else if (state_o == 2'd2) begin
            tb_irq = 1'b1;
            repeat (3) tick();
            tb_irq = 1'b0;
            eq("R9 tb ignored", state_o, 2);
            ext_irq = 4'b0100;
            tick();
            ext_irq = '0;
            run_delay(n);
            eq("R2 short delay", n, 256);
            eq("R9 ext wake service", irq_service, 1);
            eq("R9 no vector fetch", fetch_rst_vec, 0);
         end else begin
            tick();
            eq("R8 wdg pulse one cycle", wdg_rst_req, 0);
         end
      end
      wdg_on = 1'b0;

      // R4 external interrupts ignored in clock-keeping halt
      osc_irq_en = 1'b1;
      halt_req = 1'b1;
      tick();
      halt_req = 1'b0;
      ext_irq = 4'b1111;
      repeat (4) tick();
      ext_irq = '0;
      eq("R4 ext ignored", state_o, 1);
      eq("R4 cpu still off", cpu_clk_en, 0);

      // R10 reset beats timebase interrupt; R6 reset path
      tb_irq = 1'b1;
      sys_rst_req = 1'b1;
      tick();
      tb_irq = 1'b0;
      sys_rst_req = 1'b0;
      eq("R10 reset wins", state_o, 3);
      eq("R10 no service", irq_service, 0);
      eq("R6 delay clocks", {osc_clk_en, cpu_clk_en, per_clk_en}, 4);
      run_delay(n);
      eq("R6 reset delay", n, 256);
      eq("R6 vector fetch", fetch_rst_vec, 1);
      eq("R6 clocks on", {osc_clk_en, cpu_clk_en, per_clk_en}, 7);
      tick();
      eq("R6 fetch one cycle", fetch_rst_vec, 0);

      // R7 pending timebase interrupt at entry
      halt_req = 1'b1;
      tb_irq = 1'b1;
      tick();
      halt_req = 1'b0;
      eq("R7 entered halt", state_o, 1);
      eq("R7 forced mask", imask, 2);
      tick();
      tb_irq = 1'b0;
      eq("R7 immediate wake", state_o, 0);
      eq("R7 service", irq_service, 1);

      // R10 reset during delay restarts count
      sys_rst_req = 1'b1;
      tick();
      sys_rst_req = 1'b0;
      for (int k = 0; k < 99; k++) tick();
      eq("R10 mid delay", state_o, 3);
      sys_rst_req = 1'b1;
      tick();
      sys_rst_req = 1'b0;
      run_delay(n);
      eq("R10 restarted delay", n + 100, 356);
      eq("R10 fetch after restart", fetch_rst_vec, 1);

      // R2 long delay via full halt
      long_dly_sel = 1'b1;
      osc_irq_en = 1'b0;
      halt_req = 1'b1;
      tick();
      halt_req = 1'b0;
      eq("R1 full halt", state_o, 2);
      ext_irq = 4'b0001;
      tick();
      ext_irq = '0;
      run_delay(n);
      eq("R2 long delay", n, 4096);
      eq("R9 long wake service", irq_service, 1);

      summary();
   end

endmodule